// File: doc/BRIEF.md
# I2C Pending-Flag, Interrupt and Clock-Stretch Controller

This block sits beside the byte shifter of an I2C port that can work either as bus master or as addressed slave. It samples the SCL and SDA lines through synchronizers and finds start and stop conditions to keep a bus-busy flag. It counts SCL rising edges to find where each transfer frame ends. In slave mode it captures the first byte after every start and compares it with a 7-bit own address and with the all-zero general-call code. In master mode it watches the address byte for lost arbitration.

When a frame needs attention, the block raises a one-cycle interrupt, sets a sticky status bit and clears a transfer-pending flag. While that flag is clear the block pulls SCL low, which stretches the bus clock. Software sets the flag again by touching the data register or by writing a one to it. SCL is then let go only after a programmable number of system clocks. A stop request that arrives while SCL is held by this block or by another device waits until the line is free.

Top module: `i2c_stretch_ctl`

## Requirements
- R1: `bus_busy` goes to 1 after a start (SDA falls while SCL is high) and returns to 0 after a stop (SDA rises while SCL is high). Both lines pass through a two-flop synchronizer first.
- R2: In slave mode (`cfg_master`=0), the first byte after a start is taken MSB first on SCL rising edges. If its upper seven bits equal `own_addr`, the interrupt fires after the 9th rising edge (the acknowledge bit) and `addr_hit` reads 1.
- R3: In slave mode, an all-zero first byte is a general call. It sets `gen_call` and fires the interrupt after the 9th rising edge, whatever `own_addr` holds.
- R4: In slave mode, a first byte that is neither a match nor a general call fires no interrupt and leaves `pend` at 1.
- R5: In slave mode, after a match or a general call, each later 9-edge frame fires the interrupt at its 9th rising edge.
- R6: In master mode, the interrupt fires once the frame length has been reached in SCL rising edges. The frame length is `xfer_bits` plus `ack_en`, where `xfer_bits`=0 stands for 8 bits.
- R7: Each interrupt clears `pend`. While `pend` is 0, `scl_pull` is 1. After reset `pend` is 1 and `scl_pull` is 0.
- R8: `pend` is set by a `dbr_access` strobe, or by a `pin_wr` strobe with `pin_wdata`=1. A `pin_wr` strobe with `pin_wdata`=0 leaves `pend` and `scl_pull` unchanged.
- R9: Take the clock edge at which `pend` goes from 0 to 1. `scl_pull` stays 1 for exactly `tlow` further system clocks. With `tlow`=0 it drops at that same edge.
- R10: In master mode, suppose that during the first eight bits after a start, `sda_tx`=1 (released) but SDA is sampled 0 at an SCL rising edge. Then the interrupt fires at once, `pend` clears and `arb_lost` is set. `arb_lost` blocks the frame-end interrupt until the next start, and that start clears it.
- R11: A `stop_req` strobe waits until `scl_pull` is 0 and the synchronized SCL line is high. It then gives a single `stop_go` pulse.
- R12: `irq` is a single-cycle pulse. `irq_sts` is set by each interrupt and stays set until a `sts_clr` strobe.
- R13: In slave mode, `ack_pull` is 1 during the acknowledge slot of a matched or general-call first byte, that is, between its 8th and 9th rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL bus line level |
| sda_in | input | 1 | SDA bus line level |
| cfg_master | input | 1 | 1 = master mode, 0 = slave mode |
| own_addr | input | 7 | Own slave address |
| xfer_bits | input | 3 | Master data bits per frame, 0 = 8 |
| ack_en | input | 1 | Master frame includes an acknowledge bit |
| sda_tx | input | 1 | Level this master drives on SDA (1 = released) |
| tlow | input | 8 | SCL low-period delay in system clocks |
| dbr_access | input | 1 | Strobe: data register read or write |
| pin_wr | input | 1 | Strobe: write to the pending flag |
| pin_wdata | input | 1 | Value written with `pin_wr` |
| sts_clr | input | 1 | Strobe: clear sticky interrupt status |
| stop_req | input | 1 | Strobe: request a stop condition |
| scl_pull | output | 1 | 1 = drive SCL low |
| ack_pull | output | 1 | 1 = drive SDA low for the slave acknowledge |
| pend | output | 1 | Transfer-pending flag |
| irq | output | 1 | Interrupt pulse |
| irq_sts | output | 1 | Sticky interrupt status |
| bus_busy | output | 1 | Bus busy flag |
| addr_hit | output | 1 | First byte matched own address |
| gen_call | output | 1 | First byte was a general call |
| arb_lost | output | 1 | Arbitration lost during the address byte |
| stop_go | output | 1 | Pulse: launch the stop condition now |

## Verification
The bench sets the release delay against the exact edge at which the pending flag rises. A counter that is off by one shows up as a count one too long or too short, and a zero delay that still holds SCL for a cycle is caught. It clocks a mismatched address, a general call and a lost arbitration in the middle of the address byte. A design that ignores the low bit of the address byte, drops the general call, or misses arbitration would give a wrong interrupt count or a stuck SCL. It also keeps SCL low from outside after a stop request. A stop generator that checks only its own hold would fire early. Writing zero to the pending flag must leave SCL held.

// File: rtl/i2c_stretch_pkg.sv
package i2c_stretch_pkg;

  // Line events derived from the synchronized SCL/SDA pair
  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
  } line_evt_t;

endpackage

// File: rtl/i2c_line_mon.sv
module i2c_line_mon
  import i2c_stretch_pkg::*;
#(
  parameter int SYNC_W = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      scl_in,
  input  logic      sda_in,
  output logic      scl_s,
  output logic      sda_s,
  output line_evt_t evt,
  output logic      busy
);

  logic [SYNC_W-1:0] scl_ff;
  logic [SYNC_W-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;
  logic              busy_n;

  assign scl_s = scl_ff[SYNC_W-1];
  assign sda_s = sda_ff[SYNC_W-1];

  always_comb begin
    evt.start = scl_s & scl_q & sda_q & ~sda_s;
    evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
    evt.rise  = scl_s & ~scl_q;
    busy_n    = busy;
    if (evt.start)     busy_n = 1'b1;
    else if (evt.stop) busy_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy   <= 1'b0;
    end else begin
      scl_ff <= {scl_ff[SYNC_W-2:0], scl_in};
      sda_ff <= {sda_ff[SYNC_W-2:0], sda_in};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      busy   <= busy_n;
    end
  end

endmodule

// File: rtl/i2c_frame_track.sv
module i2c_frame_track
  import i2c_stretch_pkg::*;
#(
  parameter  int BYTE_W = 8,
  localparam int CNT_W  = $clog2(BYTE_W + 2),
  localparam int BSEL_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_evt_t         evt,
  input  logic              busy,
  input  logic              sda_s,
  input  logic              cfg_master,
  input  logic [BYTE_W-2:0] own_addr,
  input  logic [BSEL_W-1:0] xfer_bits,
  input  logic              ack_en,
  input  logic              sda_tx,
  output logic              irq_evt,
  output logic              addr_hit,
  output logic              gen_call,
  output logic              arb_lost,
  output logic              ack_pull
);

  logic [CNT_W-1:0]  cnt, cnt_n, cnt_inc, bits_n, flen;
  logic [BYTE_W-1:0] sh, sh_n;
  logic              first, first_n, sel, sel_n;
  logic              hit_n, gc_n, arb_n;
  logic              done, addr_ok, gc_ok, arb_now, in_addr;

  always_comb begin
    cnt_inc = cnt + CNT_W'(1);
    bits_n  = (xfer_bits == '0) ? CNT_W'(BYTE_W) : CNT_W'(xfer_bits);
    flen    = cfg_master ? bits_n + CNT_W'(ack_en) : CNT_W'(BYTE_W + 1);
    done    = evt.rise & busy & (cnt_inc == flen);
    addr_ok = (sh[BYTE_W-1:1] == own_addr);
    gc_ok   = (sh == '0);
    in_addr = first & (cnt < CNT_W'(BYTE_W));
    arb_now = cfg_master & evt.rise & busy & in_addr & sda_tx & ~sda_s & ~arb_lost;
    irq_evt = arb_now
            | (cfg_master & done & ~arb_lost)
            | (~cfg_master & done & (first ? (addr_ok | gc_ok) : sel));
    ack_pull = ~cfg_master & busy & first & (cnt == CNT_W'(BYTE_W)) & (addr_ok | gc_ok);
  end

  always_comb begin
    cnt_n   = cnt;
    sh_n    = sh;
    first_n = first;
    sel_n   = sel;
    hit_n   = addr_hit;
    gc_n    = gen_call;
    arb_n   = arb_lost | arb_now;
    if (evt.start) begin
      cnt_n   = '0;
      first_n = 1'b1;
      sel_n   = 1'b0;
      hit_n   = 1'b0;
      gc_n    = 1'b0;
      arb_n   = 1'b0;
    end else if (evt.stop) begin
      cnt_n = '0;
      sel_n = 1'b0;
    end else if (evt.rise && busy) begin
      if (in_addr) sh_n = {sh[BYTE_W-2:0], sda_s};
      if (done) begin
        cnt_n   = '0;
        first_n = 1'b0;
        if (!cfg_master && first) begin
          hit_n = addr_ok;
          gc_n  = gc_ok;
          sel_n = addr_ok | gc_ok;
        end
      end else begin
        cnt_n = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      sh       <= '0;
      first    <= 1'b0;
      sel      <= 1'b0;
      addr_hit <= 1'b0;
      gen_call <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      cnt      <= cnt_n;
      sh       <= sh_n;
      first    <= first_n;
      sel      <= sel_n;
      addr_hit <= hit_n;
      gen_call <= gc_n;
      arb_lost <= arb_n;
    end
  end

endmodule

// File: rtl/i2c_pend_hold.sv
module i2c_pend_hold #(
  parameter int LOW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_evt,
  input  logic             dbr_access,
  input  logic             pin_wr,
  input  logic             pin_wdata,
  input  logic             sts_clr,
  input  logic             stop_req,
  input  logic             scl_s,
  input  logic [LOW_W-1:0] tlow,
  output logic             pend,
  output logic             scl_pull,
  output logic             irq,
  output logic             irq_sts,
  output logic             stop_go
);

  logic [LOW_W-1:0] lcnt, lcnt_n;
  logic             pend_n, sts_n, wait_n, stop_wait, fire;

  assign scl_pull = ~pend | (lcnt != '0);

  always_comb begin
    pend_n = pend;
    if (irq_evt)                                pend_n = 1'b0;
    else if (dbr_access || (pin_wr && pin_wdata)) pend_n = 1'b1;

    lcnt_n = lcnt;
    if (pend_n && !pend)   lcnt_n = tlow;
    else if (lcnt != '0)   lcnt_n = lcnt - LOW_W'(1);

    sts_n = irq_sts;
    if (irq_evt)      sts_n = 1'b1;
    else if (sts_clr) sts_n = 1'b0;

    fire   = stop_wait & ~scl_pull & scl_s;
    wait_n = stop_wait;
    if (stop_req)  wait_n = 1'b1;
    else if (fire) wait_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b1;
      lcnt      <= '0;
      irq       <= 1'b0;
      irq_sts   <= 1'b0;
      stop_wait <= 1'b0;
      stop_go   <= 1'b0;
    end else begin
      pend      <= pend_n;
      lcnt      <= lcnt_n;
      irq       <= irq_evt;
      irq_sts   <= sts_n;
      stop_wait <= wait_n;
      stop_go   <= fire;
    end
  end

endmodule

// File: rtl/i2c_stretch_ctl.sv
module i2c_stretch_ctl
  import i2c_stretch_pkg::*;
#(
  parameter  int BYTE_W = 8,
  parameter  int LOW_W  = 8,
  parameter  int SYNC_W = 2,
  localparam int BSEL_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              cfg_master,
  input  logic [BYTE_W-2:0] own_addr,
  input  logic [BSEL_W-1:0] xfer_bits,
  input  logic              ack_en,
  input  logic              sda_tx,
  input  logic [LOW_W-1:0]  tlow,
  input  logic              dbr_access,
  input  logic              pin_wr,
  input  logic              pin_wdata,
  input  logic              sts_clr,
  input  logic              stop_req,
  output logic              scl_pull,
  output logic              ack_pull,
  output logic              pend,
  output logic              irq,
  output logic              irq_sts,
  output logic              bus_busy,
  output logic              addr_hit,
  output logic              gen_call,
  output logic              arb_lost,
  output logic              stop_go
);

  logic [1:0] rst_ff;
  logic       rst_sync_n;
  logic       scl_s, sda_s, irq_evt;
  logic       start_evt, stop_evt;
  line_evt_t  evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= '0;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  assign start_evt = evt.start;
  assign stop_evt  = evt.stop;

  i2c_line_mon #(.SYNC_W(SYNC_W)) u_line (
    .clk(clk), .rst_n(rst_sync_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .evt(evt), .busy(bus_busy)
  );

  i2c_frame_track #(.BYTE_W(BYTE_W)) u_frame (
    .clk(clk), .rst_n(rst_sync_n), .evt(evt), .busy(bus_busy), .sda_s(sda_s),
    .cfg_master(cfg_master), .own_addr(own_addr), .xfer_bits(xfer_bits),
    .ack_en(ack_en), .sda_tx(sda_tx), .irq_evt(irq_evt), .addr_hit(addr_hit),
    .gen_call(gen_call), .arb_lost(arb_lost), .ack_pull(ack_pull)
  );

  i2c_pend_hold #(.LOW_W(LOW_W)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .irq_evt(irq_evt), .dbr_access(dbr_access),
    .pin_wr(pin_wr), .pin_wdata(pin_wdata), .sts_clr(sts_clr),
    .stop_req(stop_req), .scl_s(scl_s), .tlow(tlow), .pend(pend),
    .scl_pull(scl_pull), .irq(irq), .irq_sts(irq_sts), .stop_go(stop_go)
  );

endmodule

// File: rtl/i2c_stretch_chk.sv
module i2c_stretch_chk (
  input logic clk,
  input logic rst_n,
  input logic start_evt,
  input logic stop_evt,
  input logic bus_busy,
  input logic irq,
  input logic irq_sts,
  input logic pend,
  input logic scl_pull,
  input logic pin_wr,
  input logic pin_wdata,
  input logic dbr_access,
  input logic stop_go
);

  p_busy_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> bus_busy);

  p_busy_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !start_evt) |=> !bus_busy);

  p_irq_drops_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !pend);

  p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |-> scl_pull);

  p_zero_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && pin_wr && !pin_wdata && !dbr_access) |=> (pend || irq));

  p_stop_free_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_go |-> !$past(scl_pull));

  p_irq_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_sts_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> irq_sts);

endmodule

bind i2c_stretch_ctl i2c_stretch_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start_evt(start_evt), .stop_evt(stop_evt),
  .bus_busy(bus_busy), .irq(irq), .irq_sts(irq_sts), .pend(pend),
  .scl_pull(scl_pull), .pin_wr(pin_wr), .pin_wdata(pin_wdata),
  .dbr_access(dbr_access), .stop_go(stop_go)
);

// File: tb/i2c_stretch_ctl_tb.sv
module i2c_stretch_ctl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_in, sda_in, cfg_master, ack_en, sda_tx;
  logic [6:0] own_addr;
  logic [2:0] xfer_bits;
  logic [7:0] tlow;
  logic       dbr_access, pin_wr, pin_wdata, sts_clr, stop_req;
  logic       scl_pull, ack_pull, pend, irq, irq_sts, bus_busy;
  logic       addr_hit, gen_call, arb_lost, stop_go;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  int stop_cnt = 0;

  always #10 clk = ~clk;

  i2c_stretch_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .cfg_master(cfg_master), .own_addr(own_addr), .xfer_bits(xfer_bits),
    .ack_en(ack_en), .sda_tx(sda_tx), .tlow(tlow), .dbr_access(dbr_access),
    .pin_wr(pin_wr), .pin_wdata(pin_wdata), .sts_clr(sts_clr),
    .stop_req(stop_req), .scl_pull(scl_pull), .ack_pull(ack_pull),
    .pend(pend), .irq(irq), .irq_sts(irq_sts), .bus_busy(bus_busy),
    .addr_hit(addr_hit), .gen_call(gen_call), .arb_lost(arb_lost),
    .stop_go(stop_go)
  );

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (stop_go) stop_cnt++;
  end

  function automatic bit exp_sel(input logic [7:0] b, input logic [6:0] own);
    return (b[7:1] == own) || (b == 8'h00);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit2(input logic tx, input logic bus);
    sda_tx = tx; sda_in = bus; wclk(4);
    scl_in = 1'b1; wclk(4);
    scl_in = 1'b0; wclk(4);
  endtask

  task automatic start_c();
    sda_in = 1'b1; wclk(4); scl_in = 1'b1; wclk(4);
    sda_in = 1'b0; wclk(4); scl_in = 1'b0; wclk(4);
  endtask

  task automatic stop_c();
    sda_in = 1'b0; wclk(4); scl_in = 1'b1; wclk(4);
    sda_in = 1'b1; wclk(4);
  endtask

  task automatic send8(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) bit2(b[i], b[i]);
  endtask

  // Set pend and count cycles until SCL is let go
  task automatic release_c(input bit use_dbr, output int n);
    if (use_dbr) dbr_access = 1'b1;
    else begin pin_wr = 1'b1; pin_wdata = 1'b1; end
    @(negedge clk);
    dbr_access = 1'b0; pin_wr = 1'b0; pin_wdata = 1'b0;
    n = 0;
    while (scl_pull && n < 1000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n, base;
    logic [7:0] b;
    void'($urandom(32'd2718));
    rst_n = 1'b0; scl_in = 1'b1; sda_in = 1'b1; cfg_master = 1'b0; ack_en = 1'b1;
    sda_tx = 1'b1; own_addr = 7'h3A; xfer_bits = 3'd0; tlow = 8'd6;
    dbr_access = 1'b0; pin_wr = 1'b0; pin_wdata = 1'b0; sts_clr = 1'b0; stop_req = 1'b0;
    wclk(3); rst_n = 1'b1; wclk(5);

    // Reset state
    chk(pend && !scl_pull, "R7 reset pend", int'(pend), 1);
    chk(!bus_busy && !irq_sts, "R1 reset busy", int'(bus_busy), 0);

    // Slave address match
    start_c();
    chk(bus_busy, "R1 busy after start", int'(bus_busy), 1);
    send8({7'h3A, 1'b0});
    chk(ack_pull, "R13 ack slot", int'(ack_pull), 1);
    base = irq_cnt;
    bit2(1'b0, 1'b0);
    chk(irq_cnt == base + 1, "R2 match irq", irq_cnt - base, 1);
    chk(addr_hit && !ack_pull, "R2 addr_hit", int'(addr_hit), 1);
    chk(!pend && scl_pull, "R7 hold after irq", int'(scl_pull), 1);
    chk(irq_sts, "R12 sticky set", int'(irq_sts), 1);
    // Writing zero leaves the hold
    pin_wr = 1'b1; pin_wdata = 1'b0; @(negedge clk); pin_wr = 1'b0; wclk(3);
    chk(!pend && scl_pull, "R8 zero write ignored", int'(scl_pull), 1);
    sts_clr = 1'b1; @(negedge clk); sts_clr = 1'b0;
    chk(!irq_sts, "R12 sticky clear", int'(irq_sts), 0);
    release_c(1'b1, n);
    chk(n == 6, "R9 release delay", n, 6);
    // Data frame
    base = irq_cnt;
    send8(8'hC5); bit2(1'b1, 1'b1);
    chk(irq_cnt == base + 1, "R5 data irq", irq_cnt - base, 1);
    tlow = 8'd0;
    release_c(1'b0, n);
    chk(n == 0, "R9 zero delay", n, 0);
    stop_c();
    chk(!bus_busy, "R1 busy clear", int'(bus_busy), 0);

    // Mismatch
    base = irq_cnt;
    start_c(); send8(8'h12); bit2(1'b1, 1'b1);
    chk(irq_cnt == base && pend, "R4 no irq on mismatch", irq_cnt - base, 0);
    send8(8'h55); bit2(1'b1, 1'b1);
    chk(irq_cnt == base && !scl_pull, "R4 no data irq", irq_cnt - base, 0);
    stop_c();

    // General call
    own_addr = 7'h00 + 7'h41;
    base = irq_cnt;
    start_c(); send8(8'h00);
    chk(ack_pull, "R13 gc ack slot", int'(ack_pull), 1);
    bit2(1'b0, 1'b0);
    chk(irq_cnt == base + 1 && gen_call && !addr_hit, "R3 general call", irq_cnt - base, 1);
    tlow = 8'd3;
    // Stop request while held, then other device holds SCL
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    wclk(20);
    chk(stop_cnt == 0, "R11 stop waits while held", stop_cnt, 0);
    sda_in = 1'b0;
    release_c(1'b1, n);
    chk(n == 3, "R9 delay 3", n, 3);
    wclk(12);
    chk(stop_cnt == 0, "R11 stop waits for line", stop_cnt, 0);
    scl_in = 1'b1; wclk(6);
    chk(stop_cnt == 1, "R11 stop pulse", stop_cnt, 1);
    sda_in = 1'b1; wclk(4);
    chk(!bus_busy, "R1 busy clear 2", int'(bus_busy), 0);

    // Master frame lengths
    cfg_master = 1'b1; xfer_bits = 3'd3; ack_en = 1'b0; tlow = 8'd2;
    base = irq_cnt;
    start_c(); bit2(1'b1, 1'b1); bit2(1'b0, 1'b0);
    chk(irq_cnt == base, "R6 no early irq", irq_cnt - base, 0);
    bit2(1'b1, 1'b1);
    chk(irq_cnt == base + 1, "R6 three bits", irq_cnt - base, 1);
    xfer_bits = 3'd0; ack_en = 1'b1;
    release_c(1'b1, n);
    base = irq_cnt;
    send8(8'hA7);
    chk(irq_cnt == base, "R6 ack bit pending", irq_cnt - base, 0);
    bit2(1'b1, 1'b0);
    chk(irq_cnt == base + 1, "R6 eight plus ack", irq_cnt - base, 1);
    release_c(1'b1, n);
    stop_c();

    // Arbitration loss in the address byte
    base = irq_cnt;
    start_c(); bit2(1'b1, 1'b1); bit2(1'b0, 1'b0);
    bit2(1'b1, 1'b0);
    chk(irq_cnt == base + 1 && arb_lost && !pend, "R10 arb irq", irq_cnt - base, 1);
    release_c(1'b1, n);
    for (int i = 0; i < 6; i++) bit2(1'b1, 1'b1);
    chk(irq_cnt == base + 1, "R10 frame end blocked", irq_cnt - base, 1);
    stop_c(); start_c();
    chk(!arb_lost, "R10 cleared by start", int'(arb_lost), 0);
    stop_c();

    // Random slave addressing
    cfg_master = 1'b0;
    for (int it = 0; it < 16; it++) begin
      int mode;
      bit sel;
      own_addr = 7'($urandom);
      tlow = 8'($urandom % 20);
      mode = int'($urandom % 3);
      b = (mode == 0) ? {own_addr, 1'($urandom)} : (mode == 1) ? 8'h00 : 8'($urandom);
      sel = exp_sel(b, own_addr);
      base = irq_cnt;
      start_c(); send8(b); bit2(1'b0, 1'b0);
      chk(irq_cnt - base == int'(sel), "R2 random address", irq_cnt - base, int'(sel));
      if (sel) begin
        release_c(it[0], n);
        chk(n == int'(tlow), "R9 random delay", n, int'(tlow));
        send8(8'($urandom)); bit2(1'b1, 1'b1);
        chk(irq_cnt - base == 2, "R5 random data", irq_cnt - base, 2);
        release_c(1'b1, n);
      end
      stop_c();
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule